// File: doc/BRIEF.md
# Ascending Cache-Line Stream Prefetcher

This block sits beside a second-level cache and observes the physical addresses of demand loads arriving there. It keeps the line index of the most recent demand access. When the next demand access lands on the line directly above it, the block has seen an upward walk through memory. It then requests a fill of a line further up, so that the data is in the cache before the walk reaches it.

The request leaves on a valid/ready pair and carries a line-aligned byte address. The block returns no data. The cache or its fill logic decides what to do with the request. At most one request is held at a time. A newer trigger overwrites a request that has not yet been taken. Descending walks, walks that skip lines, repeats of the same line and targets past the top of the address space never produce a request.

Top module: `stream_line_prefetcher`

## Requirements
- R1: The line index is the demand address shifted right by log2(LINE_BYTES) (6 bits for the default 64-byte line). `pfAddr` is always the target line index shifted back left, so its low log2(LINE_BYTES) bits are zero.
- R2: If a valid demand access to line L is followed by a valid demand access to line L+1, then on the clock edge that registers the second access `pfValid` goes to 1 and `pfAddr` becomes (L+3)*LINE_BYTES.
- R3: A valid demand access to the line directly below the tracked line never produces a request.
- R4: A valid demand access two or more lines above the tracked line never produces a request.
- R5: The tracked line is replaced on every valid demand access, whether or not a request fires. Cycles with `dmdValid` low leave it unchanged. So L, L+5, L+6 requests line L+8.
- R6: An access to the tracked line itself produces no request and does not affect detection of a following L+1 access.
- R7: A request waits with `pfValid` high and `pfAddr` unchanged until `pfReady` is 1 at a clock edge. After that edge `pfValid` is 0 unless a new request fires on the same edge.
- R8: A trigger that arrives while a request is still pending replaces the pending address. Requests are never held more than one deep.
- R9: A request whose target line index exceeds the highest line index of the ADDR_W-bit space is suppressed. A target equal to the highest line still fires.
- R10: The synchronous active-high `rst` clears the pending request and the tracked line. `pfValid` is 0 after reset, and the first demand access after reset never fires.
- R11: A trigger whose target equals the most recently requested line is suppressed. A different target fires as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dmdValid | input | 1 | A demand access is present this cycle |
| dmdAddr | input | ADDR_W | Physical byte address of the demand access |
| pfReady | input | 1 | Consumer takes the pending request this cycle |
| pfValid | output | 1 | A prefetch request is pending |
| pfAddr | output | ADDR_W | Line-aligned byte address of the requested line |

## Verification
The bench builds the block with a 16-bit address and the default 64-byte line. This gives a 10-bit line index, so the highest line (1023) and the targets just beyond it can be reached with a few direct accesses. The R9 boundary is tested on both sides: a target of exactly line 1023 fires, and targets of 1024 and 1025 do not. The line size stays at its default, so R1 and R2 are checked against the 6-bit shift.

// File: rtl/stream_pf_pkg.sv
package stream_pf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLast;  // capture the current demand line as the tracked line
    logic loadReq;   // capture the computed target as the pending request
    logic dropReq;   // pending request handed off, nothing new behind it
  } pfStrobes_t;

endpackage

// File: rtl/stream_pf_dp.sv
module stream_pf_dp
  import stream_pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int AHEAD      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dmdAddr,
  input  pfStrobes_t        strobes,
  output logic              seqHit,
  output logic              tgtWrap,
  output logic              tgtDup,
  output logic [ADDR_W-1:0] reqAddr
);

  localparam int OFS    = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS;

  logic [LINE_W-1:0] curLine;
  logic [LINE_W-1:0] lastLine;
  logic              lastValid;
  logic [LINE_W-1:0] reqLine;      // also the most recently requested line
  logic              recentValid;
  logic [LINE_W:0]   nextLine;
  logic [LINE_W:0]   tgtLine;
  logic              unusedLowBits;

  assign curLine       = dmdAddr[ADDR_W-1:OFS];
  assign unusedLowBits = ^dmdAddr[OFS-1:0];

  // one extra bit so that stepping off the top line is visible
  assign nextLine = {1'b0, lastLine} + (LINE_W+1)'(1);
  assign tgtLine  = {1'b0, lastLine} + (LINE_W+1)'(AHEAD);

  assign seqHit  = lastValid && (nextLine == {1'b0, curLine});
  assign tgtWrap = tgtLine[LINE_W];
  assign tgtDup  = recentValid && (tgtLine[LINE_W-1:0] == reqLine);

  always_ff @(posedge clk) begin
    if (rst) begin
      lastValid <= 1'b0;
      lastLine  <= '0;
    end else if (strobes.loadLast) begin
      lastValid <= 1'b1;
      lastLine  <= curLine;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      recentValid <= 1'b0;
      reqLine     <= '0;
    end else if (strobes.loadReq) begin
      recentValid <= 1'b1;
      reqLine     <= tgtLine[LINE_W-1:0];
    end
  end

  assign reqAddr = {reqLine, {OFS{1'b0}}};

endmodule

// File: rtl/stream_pf_ctrl.sv
module stream_pf_ctrl
  import stream_pf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dmdValid,
  input  logic       seqHit,
  input  logic       tgtWrap,
  input  logic       tgtDup,
  input  logic       pfReady,
  output pfStrobes_t strobes,
  output logic       reqValid
);

  logic fire;

  assign fire = dmdValid && seqHit && !tgtWrap && !tgtDup;

  always_comb begin
    strobes          = '0;
    strobes.loadLast = dmdValid;
    strobes.loadReq  = fire;
    strobes.dropReq  = reqValid && pfReady && !fire;
  end

  always_ff @(posedge clk) begin
    if (rst)                  reqValid <= 1'b0;
    else if (strobes.loadReq) reqValid <= 1'b1;
    else if (strobes.dropReq) reqValid <= 1'b0;
  end

endmodule

// File: rtl/stream_line_prefetcher.sv
module stream_line_prefetcher
  import stream_pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int AHEAD      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dmdValid,
  input  logic [ADDR_W-1:0] dmdAddr,
  input  logic              pfReady,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr
);

  pfStrobes_t strobes;
  logic       seqHit;
  logic       tgtWrap;
  logic       tgtDup;

  stream_pf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .dmdValid (dmdValid),
    .seqHit   (seqHit),
    .tgtWrap  (tgtWrap),
    .tgtDup   (tgtDup),
    .pfReady  (pfReady),
    .strobes  (strobes),
    .reqValid (pfValid)
  );

  stream_pf_dp #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .AHEAD      (AHEAD)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .dmdAddr (dmdAddr),
    .strobes (strobes),
    .seqHit  (seqHit),
    .tgtWrap (tgtWrap),
    .tgtDup  (tgtDup),
    .reqAddr (pfAddr)
  );

endmodule

// File: rtl/stream_pf_checker.sv
module stream_pf_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int AHEAD      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              dmdValid,
  input logic [ADDR_W-1:0] dmdAddr,
  input logic              pfReady,
  input logic              pfValid,
  input logic [ADDR_W-1:0] pfAddr
);

  localparam int OFS    = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS;

  logic [LINE_W-1:0] dLine;
  logic [LINE_W-1:0] pLine;
  assign dLine = dmdAddr[ADDR_W-1:OFS];
  assign pLine = pfAddr[ADDR_W-1:OFS];

  p_line_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    pfValid |-> (pfAddr[OFS-1:0] == '0));

  // a fresh request targets two lines past the access that completed the pair
  p_target_ahead_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pfValid) |-> (pLine == $past(dLine) + LINE_W'(AHEAD - 1)));

  p_no_spontaneous_r2: assert property (@(posedge clk) disable iff (rst)
    (!pfValid && !dmdValid) |=> !pfValid);

  p_no_descend_r3: assert property (@(posedge clk) disable iff (rst)
    (dmdValid && $past(dmdValid) && (dLine == $past(dLine) - LINE_W'(1)))
      |=> !$rose(pfValid));

  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    (pfValid && !pfReady && !dmdValid) |=> (pfValid && $stable(pfAddr)));

  p_drain_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (pfValid && pfReady && !dmdValid) |=> !pfValid);

endmodule

bind stream_line_prefetcher stream_pf_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .AHEAD      (AHEAD)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dmdValid (dmdValid),
  .dmdAddr  (dmdAddr),
  .pfReady  (pfReady),
  .pfValid  (pfValid),
  .pfAddr   (pfAddr)
);

// File: tb/stream_line_prefetcher_test.sv
`timescale 1ns/1ps
module stream_line_prefetcher_test;

  localparam int ADDR_W = 16;
  localparam int LB     = 64;
  localparam int TOP    = (1 << (ADDR_W - 6)) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              dmdValid = 1'b0;
  logic [ADDR_W-1:0] dmdAddr = '0;
  logic              pfReady = 1'b0;
  logic              pfValid;
  logic [ADDR_W-1:0] pfAddr;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  stream_line_prefetcher #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .AHEAD(3)) uut (
    .clk(clk), .rst(rst), .dmdValid(dmdValid), .dmdAddr(dmdAddr),
    .pfReady(pfReady), .pfValid(pfValid), .pfAddr(pfAddr)
  );

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; dmdValid = 1'b0; pfReady = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // one demand access; returns at the negedge after the registering edge
  task automatic access(input int line, input int ofs = 13);
    @(negedge clk);
    dmdValid = 1'b1;
    dmdAddr  = ADDR_W'(line * LB + ofs);
    @(negedge clk);
    dmdValid = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    pfReady = 1'b1;
    @(negedge clk);
    pfReady = 1'b0;
  endtask

  task automatic checkPf(input bit expV, input int expLine, input string tag);
    bit ok;
    nTests++;
    ok = expV ? (pfValid && pfAddr == ADDR_W'(expLine * LB)) : !pfValid;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: pfValid=%0b pfAddr=0x%0h, expected pfValid=%0b pfAddr=0x%0h",
               tag, pfValid, pfAddr, expV, expV ? expLine * LB : 0);
    end
  endtask

  task automatic tReset();
    doReset();
    checkPf(0, 0, "R10 idle after reset");
    access(100);
    checkPf(0, 0, "R10 first access after reset");
  endtask

  task automatic tAscend();
    doReset();
    access(10, 0);
    access(11, 63);
    checkPf(1, 13, "R2 R1 ascending pair targets L+3");
    accept();
    checkPf(0, 0, "R7 request dropped after handshake");
  endtask

  task automatic tDescend();
    doReset();
    access(20); access(19); access(18);
    checkPf(0, 0, "R3 descending walk");
  endtask

  task automatic tStride();
    doReset();
    access(30); access(32); access(34);
    checkPf(0, 0, "R4 two-line stride");
  endtask

  task automatic tTrack();
    doReset();
    access(40); access(45);
    checkPf(0, 0, "R5 jump does not fire");
    repeat (3) @(negedge clk);
    access(46);
    checkPf(1, 48, "R5 tracking follows every access");
  endtask

  task automatic tRepeat();
    doReset();
    access(50); access(50, 40);
    checkPf(0, 0, "R6 same line repeat");
    access(51);
    checkPf(1, 53, "R6 repeat keeps detection");
  endtask

  task automatic tStall();
    doReset();
    access(60); access(61);
    checkPf(1, 63, "R2 stall setup");
    repeat (3) @(negedge clk);
    checkPf(1, 63, "R7 stalled request held");
    access(62);
    checkPf(1, 64, "R8 newer trigger replaces pending");
    accept();
    checkPf(0, 0, "R8 one deep only");
  endtask

  task automatic tWrap();
    doReset();
    access(TOP - 3); access(TOP - 2);
    checkPf(1, TOP, "R9 target equal to top line fires");
    accept();
    access(TOP - 1);
    checkPf(0, 0, "R9 target one past top suppressed");
    access(TOP);
    checkPf(0, 0, "R9 target two past top suppressed");
  endtask

  task automatic tDup();
    doReset();
    access(70); access(71);
    checkPf(1, 73, "R11 setup");
    accept();
    access(70);
    checkPf(0, 0, "R3 step down before repeat");
    access(71);
    checkPf(0, 0, "R11 duplicate target suppressed");
    access(72);
    checkPf(1, 74, "R11 new target still fires");
  endtask

  initial begin
    #(8 * 200000);
    nTests++; nFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    tReset();
    tAscend();
    tDescend();
    tStride();
    tTrack();
    tRepeat();
    tStall();
    tWrap();
    tDup();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule